// File: doc/BRIEF.md
# Wide-Word Parallel CRC-32 Engine

This block computes the 32-bit cyclic redundancy remainder of a message that arrives 64 bits per clock. Each accepted word advances the 32-bit state through a fixed XOR network. The network is built at elaboration time from the generator constant, by taking the one-bit shift-register step as a matrix and raising it to a power. The first-sent half of the word is carried through 32 shifts of that matrix and combined with the second half. The current state is carried through 64 shifts, and the two results are XORed to give the next state.

A message is a run of accepted words, and the final word carries a last flag. After the final word the block spends one cycle on a flush. This cycle appends the 32 zero bits that polynomial division needs, so the user supplies only message bits. After the flush the remainder is held on the output with a done indication. A new word presented while done is high starts the next message from a zero state. A synchronous clear abandons any message in progress.

The controller has three states. ACCUM takes words. FLUSH applies the zero half-word. DONE presents the result. The transitions are:
- ACCUM to FLUSH on a valid last word.
- FLUSH to DONE unconditionally.
- DONE to ACCUM on a valid non-last word.
- DONE to FLUSH on a valid last word.
- Any state to ACCUM on clear.

Top module: `crc64_fmatrix`

## Requirements
- R1: While rst_n is low, crc_out is 0 and done is 0. The controller rests in ACCUM.
- R2: The result equals the remainder of M(x)·x^32 divided by the generator 0x1_04C1_1DB7, with a zero initial state, no bit reflection and no output inversion. in_data[63] is the first message bit of each word and in_data[0] the last. Words are ordered in time.
- R3: A word is accepted on each rising edge where in_valid is high, outside FLUSH. An edge with in_valid low, outside FLUSH, leaves crc_out unchanged, so gaps inside a message do not alter the result.
- R4: A word accepted with in_last high moves the block to FLUSH. done is 0 during FLUSH and rises at the next edge, so a W-word message sent on consecutive cycles is finished W+1 edges after its first word (9 edges for a 64-byte message).
- R5: in_valid, in_last and in_data are ignored during the FLUSH cycle.
- R6: In DONE with in_valid and clr low, done stays 1 and crc_out stays constant.
- R7: A valid word arriving in DONE begins a new message from a zero state, so that message's result does not depend on the previous one.
- R8: clr high at a rising edge sets crc_out to 0 and done to 0 and returns the controller to ACCUM. It takes priority over a word presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of state and controller |
| in_valid | input | 1 | in_data holds a message word |
| in_last | input | 1 | The presented word ends the message |
| in_data | input | 64 | Message word, bit 63 sent first |
| crc_out | output | 32 | Current remainder state, final when done is 1 |
| done | output | 1 | Result ready, held in DONE |

## Verification
The state register updates at the edge that accepts a word, so crc_out and the controller move one edge after the word is presented. The final remainder and done appear two edges after the last word: one edge to accept it and one for the flush. The bench drives on falling edges and samples on the falling edge just before its next drive. done is checked low at the first of those samples and high, with crc_out equal to a bit-serial division model, at the second. A clear is checked at the falling edge right after the edge that registers it.

// File: rtl/crc64_fmatrix_pkg.sv
package crc64_fmatrix_pkg;

    parameter int CRC_W = 32;

    typedef logic [CRC_W-1:0]            crc_vec_t;
    typedef logic [CRC_W-1:0][CRC_W-1:0] crc_cols_t;

    typedef enum logic [1:0] {
        ST_ACCUM = 2'd0,
        ST_FLUSH = 2'd1,
        ST_DONE  = 2'd2
    } crc_phase_e;

    // One shift of the augmented divider with a zero input bit.
    function automatic crc_vec_t lfsr_step(input crc_vec_t v, input crc_vec_t poly);
        crc_vec_t r;
        r = {v[CRC_W-2:0], 1'b0};
        if (v[CRC_W-1])
            r = r ^ poly;
        return r;
    endfunction

    // Column j of F^n is the image of unit vector j after n shifts.
    function automatic crc_cols_t lfsr_cols(input crc_vec_t poly, input int n);
        crc_cols_t c;
        crc_vec_t  v;
        for (int j = 0; j < CRC_W; j++) begin
            v    = '0;
            v[j] = 1'b1;
            for (int s = 0; s < n; s++)
                v = lfsr_step(v, poly);
            c[j] = v;
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_matrix_apply.sv
module crc_matrix_apply
    import crc64_fmatrix_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY   = 32'h04C1_1DB7,
    parameter int               SHIFTS = 32
) (
    input  logic [CRC_W-1:0] vec_in,
    output logic [CRC_W-1:0] vec_out
);
    localparam crc_cols_t COLS = lfsr_cols(POLY, SHIFTS);

    always_comb begin
        vec_out = '0;
        for (int j = 0; j < CRC_W; j++)
            if (vec_in[j])
                vec_out = vec_out ^ COLS[j];
    end
endmodule

// File: rtl/crc_data_fold.sv
module crc_data_fold
    import crc64_fmatrix_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY   = 32'h04C1_1DB7,
    parameter int               DATA_W = 64
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  folded
);
    // DATA_W must be a whole multiple of CRC_W.
    localparam int LANES = DATA_W / CRC_W;

    logic [LANES-1:0][CRC_W-1:0] part;

    // Lane 0 is sent first and sees the most shifts; the last lane none.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        crc_matrix_apply #(
            .POLY   (POLY),
            .SHIFTS (CRC_W * (LANES - 1 - l))
        ) u_lane (
            .vec_in  (data_in[DATA_W-1-l*CRC_W -: CRC_W]),
            .vec_out (part[l])
        );
    end

    always_comb begin
        folded = '0;
        for (int l = 0; l < LANES; l++)
            folded = folded ^ part[l];
    end
endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl
    import crc64_fmatrix_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic in_valid,
    input  logic in_last,
    output logic take_word,
    output logic from_zero,
    output logic flush_now,
    output logic done
);
    crc_phase_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_ACCUM;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ACCUM: if (in_valid && in_last) st_d = ST_FLUSH;
            ST_FLUSH: st_d = ST_DONE;
            ST_DONE:  if (in_valid) st_d = in_last ? ST_FLUSH : ST_ACCUM;
            default:  st_d = ST_ACCUM;
        endcase
        if (clr)
            st_d = ST_ACCUM;
    end

    always_comb begin
        take_word = 1'b0;
        from_zero = 1'b0;
        flush_now = 1'b0;
        done      = 1'b0;
        unique case (st_q)
            ST_ACCUM: take_word = in_valid;
            ST_FLUSH: flush_now = 1'b1;
            ST_DONE: begin
                take_word = in_valid;
                from_zero = 1'b1;
                done      = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/crc64_fmatrix.sv
module crc64_fmatrix
    import crc64_fmatrix_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY   = 32'h04C1_1DB7,
    parameter int               DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    output logic [CRC_W-1:0]  crc_out,
    output logic              done
);
    logic             take_word, from_zero, flush_now;
    logic [CRC_W-1:0] crc_q, state_base, state_adv, data_part, flushed;

    crc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .take_word (take_word),
        .from_zero (from_zero),
        .flush_now (flush_now),
        .done      (done)
    );

    assign state_base = from_zero ? '0 : crc_q;

    // State through F^DATA_W.
    crc_matrix_apply #(.POLY(POLY), .SHIFTS(DATA_W)) u_state_adv (
        .vec_in  (state_base),
        .vec_out (state_adv)
    );

    // Word halves: first half through F^CRC_W, XOR second half.
    crc_data_fold #(.POLY(POLY), .DATA_W(DATA_W)) u_fold (
        .data_in (in_data),
        .folded  (data_part)
    );

    // Appended zero half-word: state through F^CRC_W.
    crc_matrix_apply #(.POLY(POLY), .SHIFTS(CRC_W)) u_flush (
        .vec_in  (crc_q),
        .vec_out (flushed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= '0;
        else if (clr)
            crc_q <= '0;
        else if (flush_now)
            crc_q <= flushed;
        else if (take_word)
            crc_q <= state_adv ^ data_part;
    end

    assign crc_out = crc_q;
endmodule

// File: rtl/crc64_fmatrix_chk.sv
module crc64_fmatrix_chk
    import crc64_fmatrix_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             in_valid,
    input logic             in_last,
    input logic             flush_now,
    input logic             done,
    input logic [CRC_W-1:0] crc_out
);
    assert_reset_clean_R1: assert property (@(posedge clk)
        !rst_n |-> (crc_out == '0 && !done));

    assert_gap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !in_valid && !flush_now) |=> $stable(crc_out));

    assert_last_to_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && in_valid && in_last && !flush_now) |=> (flush_now && !done));

    assert_flush_to_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && flush_now) |=> done);

    assert_flush_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_now |=> !flush_now);

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr && !in_valid) |=> (done && $stable(crc_out)));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_out == '0 && !done && !flush_now));
endmodule

bind crc64_fmatrix crc64_fmatrix_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .flush_now (flush_now),
    .done      (done),
    .crc_out   (crc_out)
);

// File: tb/crc64_fmatrix_tb.sv
`timescale 1ns/1ps
module crc64_fmatrix_tb;
    localparam logic [31:0] GEN_LOW = 32'h04C1_1DB7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [63:0] in_data = '0;
    logic [31:0] crc_out;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [63:0] msg [0:15];

    always #2 clk = ~clk;

    crc64_fmatrix u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_last(in_last), .in_data(in_data), .crc_out(crc_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bit-serial augmented division: message bits MSB first, then 32 zeros.
    function automatic logic [31:0] model_crc(input int n);
        logic [31:0] x = '0;
        logic        fb;
        for (int i = 0; i < n; i++)
            for (int b = 63; b >= 0; b--) begin
                fb = x[31];
                x  = {x[30:0], msg[i][b]};
                if (fb) x = x ^ GEN_LOW;
            end
        for (int b = 0; b < 32; b++) begin
            fb = x[31];
            x  = {x[30:0], 1'b0};
            if (fb) x = x ^ GEN_LOW;
        end
        return x;
    endfunction

    task automatic run_msg(input int n, input int gap, input bit junk, input string tag);
        logic [31:0] exp;
        int          edges;
        exp   = model_crc(n);
        edges = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) edges++;
            in_valid = 1'b1; in_data = msg[i]; in_last = (i == n - 1);
            if (i < n - 1)
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk); edges++;
                    in_valid = 1'b0; in_data = ~msg[i]; in_last = 1'b1;
                end
        end
        @(negedge clk); edges++;
        chk(done == 1'b0, {"R4 flush cycle done low ", tag}, done, 0);
        if (junk) begin
            in_valid = 1'b1; in_data = ~msg[0]; in_last = 1'b1;   // R5 stimulus
        end else
            in_valid = 1'b0;
        @(negedge clk); edges++;
        in_valid = 1'b0; in_last = 1'b0;
        chk(done == 1'b1, {"R4 done after flush ", tag}, done, 1);
        chk(crc_out == exp, {"R2 remainder ", tag}, crc_out, exp);
        if (gap == 0)
            chk(edges == n + 1, {"R4 edge count ", tag}, edges, n + 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk(crc_out == 0, "R1 reset crc", crc_out, 0);
        chk(done == 0, "R1 reset done", done, 0);
        rst_n = 1'b1;

        msg[0] = '1;
        run_msg(1, 0, 0, "all-ones word");

        // Walking one, consecutive messages restart from DONE (R7).
        for (int b = 0; b < 64; b++) begin
            msg[0] = 64'd1 << b;
            run_msg(1, 0, 0, "R7 walking one");
        end

        // 64-byte message: 8 words, 9 edges.
        for (int i = 0; i < 8; i++) msg[i] = {$urandom, $urandom};
        run_msg(8, 0, 0, "R4 64-byte");

        for (int t = 0; t < 24; t++) begin
            int len = 1 + ($urandom % 12);
            for (int i = 0; i < len; i++) msg[i] = {$urandom, $urandom};
            run_msg(len, 0, 0, "random message");
        end

        for (int i = 0; i < 5; i++) msg[i] = {$urandom, $urandom};
        run_msg(5, 2, 0, "R3 gapped words");

        for (int i = 0; i < 3; i++) msg[i] = {$urandom, $urandom};
        run_msg(3, 0, 1, "R5 junk during flush");

        hold = crc_out;
        repeat (5) @(negedge clk);
        chk(done == 1, "R6 done held", done, 1);
        chk(crc_out == hold, "R6 result stable", crc_out, hold);

        // Clear in DONE.
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(crc_out == 0, "R8 clear in DONE crc", crc_out, 0);
        chk(done == 0, "R8 clear in DONE done", done, 0);

        // Clear mid-message, with a word presented in the clear cycle.
        @(negedge clk); in_valid = 1'b1; in_data = {$urandom, $urandom}; in_last = 1'b0;
        @(negedge clk); in_data = {$urandom, $urandom}; clr = 1'b1;
        @(negedge clk); in_valid = 1'b0; clr = 1'b0;
        chk(crc_out == 0, "R8 clear beats word", crc_out, 0);
        chk(done == 0, "R8 clear mid done", done, 0);
        for (int i = 0; i < 4; i++) msg[i] = {$urandom, $urandom};
        run_msg(4, 0, 0, "R8 after clear");

        // Clear during FLUSH.
        msg[0] = {$urandom, $urandom};
        @(negedge clk); in_valid = 1'b1; in_data = msg[0]; in_last = 1'b1;
        @(negedge clk); in_valid = 1'b0; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(done == 0, "R8 clear in flush done", done, 0);
        chk(crc_out == 0, "R8 clear in flush crc", crc_out, 0);
        @(negedge clk);
        chk(crc_out == 0, "R3 idle after clear", crc_out, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule